// File: doc/BRIEF.md
# Keyboard/Mouse Port Register Front End

This block is the register interface between a host bus and one keyboard or mouse port. The host sees a small window of 32-bit word registers: control, status, data, clock divisor and interrupt status. At the top of the 4 KiB window there is also a read-only identification area. The bus has separate read and write strobes. Read data is registered and appears one cycle after the read strobe. It then holds until the next read.

On the device side, received bytes come from a byte source through a valid/ready handshake. A byte is pending whenever the source's valid is high. A host read of the data register pops the pending byte and remembers it. With no byte pending, the same read returns the remembered byte again. A host write to the data register sends its low byte to the transmit side as a one-cycle strobe.

The interrupt output is a level signal built from the control register. Serial line timing is handled outside the block, and the divisor value is only held for software.

Top module: `kmi_regs`

## Requirements
- R1: After reset, control, divisor and remembered byte are 0, `irq` is low, and `rd_data` is 0.
- R2: A write at byte offset 0x000 stores `wr_data[7:0]` as control; a read there returns it in bits 7:0 and zero above.
- R3: A write at offset 0x00C stores `wr_data[7:0]` as divisor; a read there returns it in bits 7:0 and zero above.
- R4: A read at offset 0x004 returns status: bit 6 always 1, bit 4 = byte pending, bit 2 = parity bit of R5, all other bits 0.
- R5: The status parity bit is the XOR of all 8 bits of the byte most recently returned by a data read.
- R6: A read at offset 0x008 with `rx_valid` high returns `rx_byte`, remembers it, and raises `rx_ready` in that cycle only. With `rx_valid` low it returns the remembered byte and `rx_ready` stays low.
- R7: A write at offset 0x008 gives `tx_strobe` high for exactly one cycle, the cycle after the write, with `tx_byte` = `wr_data[7:0]`.
- R8: `irq` = (`rx_valid` AND control bit 4) OR control bit 3, following a control write with no further delay.
- R9: A read at offset 0x010 returns bit 1 = 1, bit 0 = byte pending, all other bits 0.
- R10: Reads at offsets 0xFE0, 0xFE4, up to 0xFFC return, in that order, 0x50, 0x10, 0x04, 0x00, 0x0D, 0xF0, 0x05, 0xB1 in bits 7:0.
- R11: A read at any other offset returns 0. A write to any offset except 0x000, 0x008 and 0x00C changes no register and gives no transmit strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| addr | input | 12 | Byte offset of the access |
| rd_en | input | 1 | Read strobe |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Registered read data, valid the cycle after `rd_en` |
| rx_valid | input | 1 | Device side has a received byte |
| rx_byte | input | 8 | Received byte |
| rx_ready | output | 1 | Pops the received byte |
| tx_strobe | output | 1 | One-cycle transmit request |
| tx_byte | output | 8 | Byte to transmit |
| irq | output | 1 | Level interrupt |

## Verification
The bench reads the data register twice, first with a byte waiting and then with none. A design that popped without a pending byte, or that dropped the remembered byte, would return the wrong value or pulse `rx_ready` falsely. Parity is checked after reading an even-weight byte and an odd-weight byte, which catches parity taken from the wrong byte or only part of it. The interrupt is checked with only the receive enable set, with and without a pending byte, and with only the transmit-enable bit set. This exposes a swapped or missing term. Writes to the status offset and to unmapped offsets are followed by readback of control and divisor and a watch on `tx_strobe`, so a decoder that aliased those offsets would be seen.

// File: rtl/kmi_pkg.sv
// Package kmi_pkg
// Shared offsets, bit positions and the identification table for the
// keyboard/mouse register front end. Assumes 32-bit word addressing.
package kmi_pkg;
    localparam int REG_CTRL = 0;
    localparam int REG_STAT = 1;
    localparam int REG_DATA = 2;
    localparam int REG_DIV  = 3;
    localparam int REG_IRQS = 4;

    localparam int CTRL_RXIE_BIT = 4;
    localparam int CTRL_TXIE_BIT = 3;

    localparam int STAT_TXEMPTY_BIT = 6;
    localparam int STAT_RXFULL_BIT  = 4;
    localparam int STAT_PARITY_BIT  = 2;

    localparam int IRQS_FIXED_BIT = 1;

    // Identification byte for word index 0..7 of the ID window.
    function automatic logic [7:0] id_byte(input logic [2:0] idx);
        case (idx)
            3'd0: id_byte = 8'h50;
            3'd1: id_byte = 8'h10;
            3'd2: id_byte = 8'h04;
            3'd3: id_byte = 8'h00;
            3'd4: id_byte = 8'h0D;
            3'd5: id_byte = 8'hF0;
            3'd6: id_byte = 8'h05;
            default: id_byte = 8'hB1;
        endcase
    endfunction
endpackage

// File: rtl/kmi_cfg_regs.sv
// Module kmi_cfg_regs
// Holds the control and divisor bytes. Each loads on its own write enable.
// Assumes the enables are already decoded and mutually exclusive.
module kmi_cfg_regs #(
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctrl_we,
    input  logic              div_we,
    input  logic [BYTE_W-1:0] wbyte,
    output logic [BYTE_W-1:0] ctrl_q,
    output logic [BYTE_W-1:0] div_q
);
    // Control byte storage.
    always_ff @(posedge clk) begin
        if (!rst_n)       ctrl_q <= '0;
        else if (ctrl_we) ctrl_q <= wbyte;
    end

    // Divisor byte storage, kept for readback only.
    always_ff @(posedge clk) begin
        if (!rst_n)      div_q <= '0;
        else if (div_we) div_q <= wbyte;
    end
endmodule

// File: rtl/kmi_rx_hold.sv
// Module kmi_rx_hold
// Pops the pending receive byte on a data read and remembers the byte last
// handed to the host. It also gives that byte's parity.
// Assumes data_rd is a single-cycle decoded read strobe.
module kmi_rx_hold #(
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              data_rd,
    input  logic              rx_valid,
    input  logic [BYTE_W-1:0] rx_byte,
    output logic              rx_ready,
    output logic [BYTE_W-1:0] data_view,
    output logic              parity
);
    logic [BYTE_W-1:0] last_q;

    // Pop only when the host reads data and a byte is waiting.
    always_comb rx_ready = data_rd & rx_valid;

    // Value a data read returns this cycle.
    always_comb data_view = rx_valid ? rx_byte : last_q;

    // Parity of the remembered byte, computed live.
    always_comb parity = ^last_q;

    // Remember the byte that was popped.
    always_ff @(posedge clk) begin
        if (!rst_n)        last_q <= '0;
        else if (rx_ready) last_q <= rx_byte;
    end
endmodule

// File: rtl/kmi_tx_pulse.sv
// Module kmi_tx_pulse
// Turns a decoded data write into a registered one-cycle transmit strobe
// with its byte. Assumes data_we lasts one cycle per write.
module kmi_tx_pulse #(
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              data_we,
    input  logic [BYTE_W-1:0] wbyte,
    output logic              tx_strobe,
    output logic [BYTE_W-1:0] tx_byte
);
    // Strobe and byte register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_strobe <= 1'b0;
            tx_byte   <= '0;
        end else begin
            tx_strobe <= data_we;
            if (data_we) tx_byte <= wbyte;
        end
    end
endmodule

// File: rtl/kmi_read_mux.sv
// Module kmi_read_mux
// Picks the read value from the decoded selects and registers it onto the
// bus. Assumes at most one select is high. When no select is high the
// value is zero.
module kmi_read_mux #(
    parameter int DATA_W = 32,
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_en,
    input  logic              sel_ctrl,
    input  logic              sel_stat,
    input  logic              sel_data,
    input  logic              sel_div,
    input  logic              sel_irqs,
    input  logic              sel_id,
    input  logic [2:0]        id_idx,
    input  logic [BYTE_W-1:0] ctrl_q,
    input  logic [BYTE_W-1:0] div_q,
    input  logic [BYTE_W-1:0] data_view,
    input  logic              pending,
    input  logic              parity,
    output logic [DATA_W-1:0] rd_data
);
    import kmi_pkg::*;

    localparam int PAD_W = DATA_W - BYTE_W;

    logic [BYTE_W-1:0] stat_b, irqs_b, id_b, pick;

    // Status and interrupt-status bytes.
    always_comb begin
        stat_b = '0;
        stat_b[STAT_TXEMPTY_BIT] = 1'b1;
        stat_b[STAT_RXFULL_BIT]  = pending;
        stat_b[STAT_PARITY_BIT]  = parity;
        irqs_b = '0;
        irqs_b[IRQS_FIXED_BIT] = 1'b1;
        irqs_b[0] = pending;
        id_b = BYTE_W'(id_byte(id_idx));
    end

    // One-hot select of the read byte.
    always_comb begin
        pick = ({BYTE_W{sel_ctrl}} & ctrl_q)
             | ({BYTE_W{sel_stat}} & stat_b)
             | ({BYTE_W{sel_data}} & data_view)
             | ({BYTE_W{sel_div}}  & div_q)
             | ({BYTE_W{sel_irqs}} & irqs_b)
             | ({BYTE_W{sel_id}}   & id_b);
    end

    // Register read data on each read strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)     rd_data <= '0;
        else if (rd_en) rd_data <= {{PAD_W{1'b0}}, pick};
    end
endmodule

// File: rtl/kmi_regs.sv
// Module kmi_regs
// Top of the keyboard/mouse register front end: address decode, the
// interrupt level and the submodule wiring. Assumes ADDR_W covers a 4 KiB
// window, with the ID area in its top 32 bytes.
module kmi_regs #(
    parameter int ADDR_W = 12,
    parameter int DATA_W = 32,
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              rd_en,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] rd_data,
    input  logic              rx_valid,
    input  logic [BYTE_W-1:0] rx_byte,
    output logic              rx_ready,
    output logic              tx_strobe,
    output logic [BYTE_W-1:0] tx_byte,
    output logic              irq
);
    import kmi_pkg::*;

    localparam int WORD_W = ADDR_W - 2;
    localparam int ID_LSB = 5;

    logic [WORD_W-1:0] word;
    logic sel_ctrl, sel_stat, sel_data, sel_div, sel_irqs, sel_id;
    logic [BYTE_W-1:0] ctrl_q, div_q, data_view, wbyte;
    logic parity;

    // Word address decode; the ID area is the all-ones top region.
    always_comb begin
        word     = addr[ADDR_W-1:2];
        sel_id   = &addr[ADDR_W-1:ID_LSB];
        sel_ctrl = (word == WORD_W'(REG_CTRL));
        sel_stat = (word == WORD_W'(REG_STAT));
        sel_data = (word == WORD_W'(REG_DATA));
        sel_div  = (word == WORD_W'(REG_DIV));
        sel_irqs = (word == WORD_W'(REG_IRQS));
        wbyte    = wr_data[BYTE_W-1:0];
    end

    // Interrupt level from the stored control and the pending byte.
    always_comb irq = (rx_valid & ctrl_q[CTRL_RXIE_BIT]) | ctrl_q[CTRL_TXIE_BIT];

    kmi_cfg_regs #(.BYTE_W(BYTE_W)) cfg_i (
        .clk(clk), .rst_n(rst_n),
        .ctrl_we(wr_en & sel_ctrl), .div_we(wr_en & sel_div),
        .wbyte(wbyte), .ctrl_q(ctrl_q), .div_q(div_q)
    );

    kmi_rx_hold #(.BYTE_W(BYTE_W)) rx_i (
        .clk(clk), .rst_n(rst_n),
        .data_rd(rd_en & sel_data), .rx_valid(rx_valid), .rx_byte(rx_byte),
        .rx_ready(rx_ready), .data_view(data_view), .parity(parity)
    );

    kmi_tx_pulse #(.BYTE_W(BYTE_W)) tx_i (
        .clk(clk), .rst_n(rst_n),
        .data_we(wr_en & sel_data), .wbyte(wbyte),
        .tx_strobe(tx_strobe), .tx_byte(tx_byte)
    );

    kmi_read_mux #(.DATA_W(DATA_W), .BYTE_W(BYTE_W)) mux_i (
        .clk(clk), .rst_n(rst_n), .rd_en(rd_en),
        .sel_ctrl(sel_ctrl), .sel_stat(sel_stat), .sel_data(sel_data),
        .sel_div(sel_div), .sel_irqs(sel_irqs), .sel_id(sel_id),
        .id_idx(addr[4:2]),
        .ctrl_q(ctrl_q), .div_q(div_q), .data_view(data_view),
        .pending(rx_valid), .parity(parity), .rd_data(rd_data)
    );
endmodule

// File: rtl/kmi_regs_chk.sv
// Module kmi_regs_chk
// Property checker for kmi_regs, attached by bind. It watches the handshake,
// the transmit strobe, the interrupt level and control loading.
module kmi_regs_chk #(
    parameter int ADDR_W = 12,
    parameter int DATA_W = 32,
    parameter int BYTE_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] addr,
    input logic              rd_en,
    input logic              wr_en,
    input logic [DATA_W-1:0] wr_data,
    input logic              rx_valid,
    input logic              rx_ready,
    input logic              tx_strobe,
    input logic              irq,
    input logic [BYTE_W-1:0] ctrl_q
);
    // A pop is only allowed while a byte is offered (R6).
    p_pop_needs_byte_r6: assert property (@(posedge clk) disable iff (!rst_n)
        rx_ready |-> rx_valid);

    // A pop only happens during a host read (R6).
    p_pop_on_read_r6: assert property (@(posedge clk) disable iff (!rst_n)
        rx_ready |-> rd_en);

    // The transmit strobe follows a write one cycle earlier (R7).
    p_tx_after_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
        tx_strobe |-> $past(wr_en));

    // The transmit-enable bit forces the interrupt high (R8).
    p_irq_forced_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_q[3] |-> irq);

    // With no force and no pending byte, the interrupt is low (R8).
    p_irq_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctrl_q[3] && !rx_valid) |-> !irq);

    // A write at offset zero loads the control byte (R2).
    p_ctrl_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(wr_en) && ($past(addr) == '0)) |-> (ctrl_q == $past(wr_data[BYTE_W-1:0])));
endmodule

bind kmi_regs kmi_regs_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .BYTE_W(BYTE_W)) chk_i (
    .clk(clk), .rst_n(rst_n), .addr(addr), .rd_en(rd_en), .wr_en(wr_en),
    .wr_data(wr_data), .rx_valid(rx_valid), .rx_ready(rx_ready),
    .tx_strobe(tx_strobe), .irq(irq), .ctrl_q(ctrl_q)
);

// File: tb/kmi_regs_tb_top.sv
// Scoreboard bench for kmi_regs. Driver tasks queue the expected read data,
// and a monitor on the falling edge pops and compares it.
module kmi_regs_tb_top;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [11:0] addr = '0;
    logic        rd_en = 1'b0;
    logic        wr_en = 1'b0;
    logic [31:0] wr_data = '0;
    logic [31:0] rd_data;
    logic        rx_valid = 1'b0;
    logic [7:0]  rx_byte = '0;
    logic        rx_ready;
    logic        tx_strobe;
    logic [7:0]  tx_byte;
    logic        irq;

    int vectors = 0;
    int errors  = 0;
    logic [31:0] exp_q[$];
    string       tag_q[$];
    logic        rd_seen = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    kmi_regs dut_i (
        .clk(clk), .rst_n(rst_n), .addr(addr), .rd_en(rd_en), .wr_en(wr_en),
        .wr_data(wr_data), .rd_data(rd_data), .rx_valid(rx_valid),
        .rx_byte(rx_byte), .rx_ready(rx_ready), .tx_strobe(tx_strobe),
        .tx_byte(tx_byte), .irq(irq)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // Record which cycles carried a read.
    always @(posedge clk) rd_seen <= rd_en;

    // Monitor: compare the registered read data against the queue.
    always @(negedge clk) begin
        if (rd_seen) begin
            if (exp_q.size() == 0) begin
                vectors++; errors++;
                $display("FAIL scoreboard: actual %h expected none", rd_data);
            end else begin
                check(tag_q.pop_front(), rd_data, exp_q.pop_front());
            end
        end
    end

    task automatic bus_read(input logic [11:0] a, input logic [31:0] exp, input string tag);
        @(negedge clk);
        addr = a; rd_en = 1'b1;
        exp_q.push_back(exp); tag_q.push_back(tag);
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic data_read(input logic [31:0] exp, input logic exp_pop, input string tag);
        @(negedge clk);
        addr = 12'h008; rd_en = 1'b1;
        exp_q.push_back(exp); tag_q.push_back(tag);
        #1 check({tag, " rx_ready"}, {31'b0, rx_ready}, {31'b0, exp_pop});
        @(negedge clk);
        rd_en = 1'b0;
        if (exp_pop) rx_valid = 1'b0;
    endtask

    task automatic bus_write(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        addr = a; wr_data = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic offer(input logic [7:0] b);
        @(negedge clk);
        rx_byte = b; rx_valid = 1'b1;
    endtask

    initial begin
        fork
            begin
                repeat (5000) @(posedge clk);
                vectors++; errors++;
                $display("FAIL watchdog: actual timeout expected completion");
                $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
                $finish;
            end
        join_none

        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        check("R1 irq after reset", {31'b0, irq}, 32'h0);
        check("R1 rd_data after reset", rd_data, 32'h0);
        bus_read(12'h000, 32'h0, "R1 ctrl reset");
        bus_read(12'h00C, 32'h0, "R1 div reset");
        data_read(32'h0, 1'b0, "R1 last byte reset");
        bus_read(12'h004, 32'h40, "R4 status idle");
        bus_read(12'h010, 32'h2, "R9 irq status idle");

        // R2: control write keeps only the low byte
        bus_write(12'h000, 32'hA5A5_A510);
        bus_read(12'h000, 32'h10, "R2 ctrl readback");
        check("R8 rx enable no byte", {31'b0, irq}, 32'h0);

        // R8/R4/R9: a byte waiting
        offer(8'h3C);
        #1 check("R8 rx enable with byte", {31'b0, irq}, 32'h1);
        bus_read(12'h004, 32'h50, "R4 status pending");
        bus_read(12'h010, 32'h3, "R9 irq status pending");

        // R6/R5: pop an even-weight byte
        data_read(32'h3C, 1'b1, "R6 pop");
        bus_read(12'h004, 32'h40, "R5 even parity");
        #1 check("R8 low after pop", {31'b0, irq}, 32'h0);

        // R5: odd-weight byte
        offer(8'h07);
        data_read(32'h07, 1'b1, "R6 pop second");
        bus_read(12'h004, 32'h44, "R5 odd parity");

        // R6: no pending byte, the remembered byte returns again
        data_read(32'h07, 1'b0, "R6 repeat");

        // R8: transmit enable forces irq
        bus_write(12'h000, 32'h08);
        #1 check("R8 forced", {31'b0, irq}, 32'h1);
        bus_write(12'h000, 32'h00);
        #1 check("R8 cleared", {31'b0, irq}, 32'h0);

        // R3: divisor
        bus_write(12'h00C, 32'h0000_1234);
        bus_read(12'h00C, 32'h34, "R3 div readback");

        // R7: transmit strobe
        bus_write(12'h008, 32'hABCD_EF5A);
        check("R7 strobe high", {31'b0, tx_strobe}, 32'h1);
        check("R7 byte", {24'b0, tx_byte}, 32'h5A);
        @(negedge clk);
        check("R7 strobe single", {31'b0, tx_strobe}, 32'h0);

        // R10: identification window
        for (int i = 0; i < 8; i++) begin
            logic [7:0] idv;
            case (i)
                0: idv = 8'h50; 1: idv = 8'h10; 2: idv = 8'h04; 3: idv = 8'h00;
                4: idv = 8'h0D; 5: idv = 8'hF0; 6: idv = 8'h05; default: idv = 8'hB1;
            endcase
            bus_read(12'hFE0 + 12'(i*4), {24'b0, idv}, "R10 id byte");
        end

        // R11: unmapped offsets and read-only registers
        bus_read(12'h014, 32'h0, "R11 unmapped read");
        bus_read(12'h800, 32'h0, "R11 far unmapped read");
        bus_write(12'h014, 32'hFF);
        check("R11 no strobe unmapped", {31'b0, tx_strobe}, 32'h0);
        bus_write(12'h004, 32'hFF);
        check("R11 no strobe status", {31'b0, tx_strobe}, 32'h0);
        bus_write(12'h010, 32'hFF);
        bus_read(12'h000, 32'h0, "R11 ctrl untouched");
        bus_read(12'h00C, 32'h34, "R11 div untouched");
        check("R11 irq untouched", {31'b0, irq}, 32'h0);

        repeat (3) @(negedge clk);
        if (exp_q.size() != 0) begin
            vectors++; errors++;
            $display("FAIL scoreboard: actual %0d left expected 0", exp_q.size());
        end
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end
endmodule